// File: doc/BRIEF.md
# ODT Power-Down Exit Timing Selector

This block sits in a memory device model or controller shadow and decides, for every change of the on-die-termination request, whether the termination follows synchronous or asynchronous timing. It watches the clock-enable input. Each time clock-enable rises, a power-down exit has happened, and a counter starts to measure the cycles since that exit. A termination request that arrives early after the exit is handled with the slower power-down worst-case delay. A request that arrives after the programmed exit interval uses the normal turn-on or turn-off latency.

All delays are programmable cycle counts. The asynchronous case is modelled as a fixed worst-case number of cycles, which is the ceiling of the maximum analog delay. The termination-enable output changes a set number of cycles after the request is sampled. A flag output shows which timing mode governs the change that is pending or was most recent.

Top module: `odt_exit_timing_sel`

## Requirements
- R1: During reset and directly after it, `rtt_en_o` is 0 and `async_mode_o` is 0.
- R2: While `cke_i` is sampled low, the exit counter is held at 0 and no new termination change starts. A difference between `odt_i` and `rtt_en_o` leaves `rtt_en_o` unchanged.
- R3: Let n be the number of rising edges since the first edge that sampled `cke_i` high, so the request is sampled at edge E+n. The change is synchronous (`async_mode_o`=0) when n >= `axpd_cyc_i`, and asynchronous (`async_mode_o`=1) otherwise.
- R4: Under synchronous timing, `rtt_en_o` takes the requested level `aond_cyc_i` edges after the request edge for turn-on (0 to 1), and `aofd_cyc_i` edges after it for turn-off.
- R5: Under asynchronous timing, the turn-on delay is `aonpd_cyc_i` edges and the turn-off delay is `aofpd_cyc_i` edges. A programmed delay of 0 acts as 1.
- R6: `async_mode_o` is loaded on the edge that accepts a request and keeps its value until the next request is accepted. It does not change while a change is pending.
- R7: A change of `odt_i` while a change is pending is not accepted. On the first edge after completion, if `odt_i` differs from `rtt_en_o`, a new change starts with timing chosen at that edge.
- R8: The exit counter saturates at `axpd_cyc_i`, so an arbitrarily long time since exit still selects synchronous timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock-enable; low means power-down |
| odt_i | input | 1 | Requested termination level |
| axpd_cyc_i | input | CNT_W | Minimum exit interval in cycles |
| aond_cyc_i | input | DLY_W | Synchronous turn-on delay |
| aofd_cyc_i | input | DLY_W | Synchronous turn-off delay |
| aonpd_cyc_i | input | DLY_W | Asynchronous worst-case turn-on delay |
| aofpd_cyc_i | input | DLY_W | Asynchronous worst-case turn-off delay |
| rtt_en_o | output | 1 | Termination enable |
| async_mode_o | output | 1 | 1 when asynchronous timing governs the current or last change |

## Verification
The assertions assume that the cycle thresholds are static while reset is released. The saturation and hold properties only have meaning under a fixed programming. They also assume that `cke_i` and `odt_i` settle ahead of each rising edge, which meets the setup requirement. The bench programs all thresholds before it releases reset and never changes them afterwards. It drives every input on the falling clock edge, so each value is stable for half a period before it is sampled.

// File: rtl/odt_sel_pkg.sv
package odt_sel_pkg;
  typedef enum logic {
    MODE_SYNC  = 1'b0,
    MODE_ASYNC = 1'b1
  } odt_mode_e;
endpackage

// File: rtl/odt_exit_counter.sv
module odt_exit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic [CNT_W-1:0] axpd_i,
  output logic             settled_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!cke_i)          cnt_q <= '0;
    else if (cnt_q < axpd_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q >= axpd_i);

  assert_cnt_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (cnt_q == '0));

  assert_cnt_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && cnt_q == axpd_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/odt_delay_timer.sv
module odt_delay_timer #(
  parameter int DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tgt_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             busy_o,
  output logic             rtt_o
);
  logic [DLY_W-1:0] rem_q;
  logic             busy_q, tgt_q, rtt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      tgt_q  <= 1'b0;
      rtt_q  <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rem_q  <= delay_i;
      tgt_q  <= tgt_i;
    end else if (busy_q) begin
      // zero-delay programming behaves as one cycle
      if (rem_q <= 1) begin
        rtt_q  <= tgt_q;
        busy_q <= 1'b0;
      end else begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign rtt_o  = rtt_q;

  assert_rtt_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(rtt_q));

  assert_no_early_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && rem_q > 1) |=> busy_q);
endmodule

// File: rtl/odt_exit_timing_sel.sv
module odt_exit_timing_sel
  import odt_sel_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             odt_i,
  input  logic [CNT_W-1:0] axpd_cyc_i,
  input  logic [DLY_W-1:0] aond_cyc_i,
  input  logic [DLY_W-1:0] aofd_cyc_i,
  input  logic [DLY_W-1:0] aonpd_cyc_i,
  input  logic [DLY_W-1:0] aofpd_cyc_i,
  output logic             rtt_en_o,
  output logic             async_mode_o
);
  logic             settled, busy, start, rtt;
  odt_mode_e        mode_d, mode_q;
  logic [DLY_W-1:0] delay_sel;

  odt_exit_counter #(.CNT_W(CNT_W)) u_exit_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cke_i     (cke_i),
    .axpd_i    (axpd_cyc_i),
    .settled_o (settled)
  );

  assign start  = cke_i && !busy && (odt_i != rtt);
  assign mode_d = settled ? MODE_SYNC : MODE_ASYNC;

  always_comb begin
    unique case ({mode_d, odt_i})
      {MODE_SYNC,  1'b1}: delay_sel = aond_cyc_i;
      {MODE_SYNC,  1'b0}: delay_sel = aofd_cyc_i;
      {MODE_ASYNC, 1'b1}: delay_sel = aonpd_cyc_i;
      default:            delay_sel = aofpd_cyc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_SYNC;
    else if (start) mode_q <= mode_d;
  end

  odt_delay_timer #(.DLY_W(DLY_W)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tgt_i   (odt_i),
    .delay_i (delay_sel),
    .busy_o  (busy),
    .rtt_o   (rtt)
  );

  assign rtt_en_o     = rtt;
  assign async_mode_o = (mode_q == MODE_ASYNC);

  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(async_mode_o));

  assert_pd_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_i && !busy) |=> ($stable(rtt_en_o) && !busy));
endmodule

// File: tb/odt_exit_timing_sel_bench.sv
module odt_exit_timing_sel_bench;
  localparam int AXPD = 4, AOND = 2, AOFD = 3, AONPD = 6, AOFPD = 7;
  localparam int NV = 6;
  // stimulus: exit gap n; expected: async flag
  localparam int  V_GAP[NV]   = '{0, 3, 4, 10, 1, 40};
  localparam bit  V_ASYNC[NV] = '{1, 1, 0, 0, 1, 0};

  logic clk_i = 0, rst_ni = 0, cke_i = 0, odt_i = 0;
  logic rtt_en_o, async_mode_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  odt_exit_timing_sel u_odt_exit_timing_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .odt_i(odt_i),
    .axpd_cyc_i(8'(AXPD)), .aond_cyc_i(6'(AOND)), .aofd_cyc_i(6'(AOFD)),
    .aonpd_cyc_i(6'(AONPD)), .aofpd_cyc_i(6'(AOFPD)),
    .rtt_en_o(rtt_en_o), .async_mode_o(async_mode_o));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count negedges until rtt reaches lvl; change at edge s+d shows at k=d+1
  task automatic measure(input logic lvl, output int k);
    k = 0;
    do begin
      @(negedge clk_i);
      k++;
    end while (rtt_en_o != lvl && k < 60);
  endtask

  initial begin
    int k;
    logic lvl;
    int d;
    repeat (3) @(negedge clk_i);
    chk("R1 rtt", rtt_en_o, 0);
    chk("R1 mode", async_mode_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2: request ignored in power-down
    odt_i = 1;
    repeat (10) @(negedge clk_i);
    chk("R2 rtt held", rtt_en_o, 0);
    chk("R2 mode held", async_mode_o, 0);
    cke_i = 1;  // request already pending, n=0 -> async turn-on
    measure(1'b1, k);
    chk("R3/R5 exit with pending request delay", k, AONPD + 1);
    chk("R3 async flag", async_mode_o, 1);

    // vector walk (R3, R4, R5, R8)
    for (int i = 0; i < NV; i++) begin
      lvl = !rtt_en_o;
      d = V_ASYNC[i] ? (lvl ? AONPD : AOFPD) : (lvl ? AOND : AOFD);
      @(negedge clk_i); cke_i = 0;
      repeat (3) @(negedge clk_i);
      cke_i = 1;
      repeat (V_GAP[i]) @(negedge clk_i);
      odt_i = lvl;
      measure(lvl, k);
      chk(V_ASYNC[i] ? "R5 async delay" : (V_GAP[i] > 20 ? "R8 saturated sync delay" : "R4 sync delay"), k, d + 1);
      chk("R3/R6 mode flag", async_mode_o, int'(V_ASYNC[i]));
    end

    // R7: toggle back while pending (rtt now 0 after last vector? ensure 1 first)
    if (rtt_en_o == 1'b0) begin
      odt_i = 1;
      measure(1'b1, k);
    end
    repeat (2) @(negedge clk_i);
    odt_i = 0;              // sync turn-off at s, done s+3
    @(negedge clk_i); k = 1;
    odt_i = 1;              // arrives while pending
    @(negedge clk_i); k++;
    @(negedge clk_i); k++;  // k=3
    chk("R7 still pending old level", rtt_en_o, 1);
    @(negedge clk_i); k++;  // k=4
    chk("R7 first change done", rtt_en_o, 0);
    repeat (2) @(negedge clk_i);  // k=6
    chk("R7 deferred change not yet", rtt_en_o, 0);
    @(negedge clk_i);             // k=7
    chk("R7 deferred change applied", rtt_en_o, 1);
    chk("R6 deferred mode sync", async_mode_o, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule